// File: doc/BRIEF.md
# Flash Page Load Controller

This controller sits behind the command decoder of a page-programmed flash array. Once the decoder has accepted a page-program or write-buffer command, the controller takes in the data loads that follow and steers each one into a 128-byte page latch through byte-lane write enables. It also decides when the load period is over. At that point it starts the array programming step and hands over the page address it captured.

The controller is armed for one of two jobs, and the width mode is fixed at arming time:

- **Program loads** end in one of two ways:
  - an inactivity timeout, counted in clock cycles from the arm or from the last accepted load;
  - two loads in a row to the same location. The second of these is a terminator and is not stored.
- **Write-buffer loads** only fill the latch, which then acts as scratch SRAM. They end on a shorter timeout and start nothing.

Loads may arrive in any order. A program arm first erases the whole latch to FFh, so any location that is not loaded is programmed as erased.

The programming engine itself is outside this block. A stub acknowledges each start pulse, and the controller stays parked until that acknowledge arrives.

Top module: `flash_page_loader`

## Requirements
- R1: After reset the controller is idle: `loading`, `buf_clr`, `load_end`, `pgm_start`, `rsvd_flag` are 0 and `buf_be` is 2'b00.
- R2: An arm (`arm_valid`) accepted while idle with `arm_buf`=0 raises `buf_clr` in that same cycle, so every latch byte returns to FFh. An arm with `arm_buf`=1 leaves `buf_clr` low.
- R3: Each load strobe accepted while loading writes the latch in the same cycle, with `buf_widx` = `ld_addr[6:1]`:
  - In byte mode, `ld_addr[0]`=0 selects lane 0 (`buf_be`=2'b01, data on bits 7:0) and 1 selects lane 1 (2'b10, data on bits 15:8). `buf_wdata` carries `ld_data[7:0]` on both halves.
  - In word mode, `buf_be`=2'b11, `buf_wdata`=`ld_data`, and `ld_addr[0]` is ignored.
  - Loads may come in any order.
- R4: A program load ends after TMO_PGM consecutive loading cycles with no strobe, counted from the arm or from the last accepted strobe. `load_end` and `pgm_start` then pulse for one cycle in the cycle that follows the last idle cycle.
- R5: In program mode, a strobe whose location equals that of the immediately preceding accepted strobe ends the load.
  - "Same location" means the same `ld_addr`; in word mode `ld_addr[0]` is not compared.
  - That strobe writes nothing. `load_end` and `pgm_start` pulse in the next cycle.
  - `end_dup` is 1 with `load_end` for this ending and 0 for a timeout ending.
- R6: The terminating strobe should carry zero. If it does not, `rsvd_flag` pulses together with `load_end`. In byte mode only `ld_data[7:0]` is tested; in word mode all 16 bits are tested.
- R7: `pgm_page` equals `ld_addr[19:7]` of the first accepted strobe of the load, or 0 if none was accepted. It holds that value from `pgm_start` until `pgm_ack`.
- R8: In write-buffer mode, a repeated location is stored as an ordinary write. The load ends after TMO_BUF strobe-free cycles with a `load_end` pulse, no `pgm_start`, and a direct return to idle.
- R9: The width mode is sampled from `arm_word` at the arm. Changes on `arm_word` during the load have no effect.
- R10: After `pgm_start` the controller waits, with `loading` low, until `pgm_ack`. Strobes and arms during the wait write nothing and are dropped; the controller returns to idle on the cycle after `pgm_ack`.
- R11: Load strobes while idle write nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Command decoder accepted a load command (one cycle) |
| arm_buf | input | 1 | 1 = write-buffer command, 0 = page-program command |
| arm_word | input | 1 | Width select sampled at arm: 1 = word loads, 0 = byte loads |
| ld_stb | input | 1 | Synchronized load strobe (one cycle per load) |
| ld_addr | input | ADDR_W | Byte address of the load; bit 0 is the byte-select bit |
| ld_data | input | 16 | Load data; byte mode uses bits 7:0 |
| pgm_ack | input | 1 | Programming engine finished |
| loading | output | 1 | Load period open |
| buf_clr | output | 1 | Erase the whole page latch to FFh |
| buf_be | output | 2 | Page latch byte-lane write enables |
| buf_widx | output | 6 | Page latch word index |
| buf_wdata | output | 16 | Page latch write data |
| load_end | output | 1 | Load period ended (one cycle) |
| end_dup | output | 1 | Valid with load_end: 1 = repeated location, 0 = timeout |
| rsvd_flag | output | 1 | Terminator carried a non-zero value (with load_end) |
| pgm_start | output | 1 | Start page programming (one cycle) |
| pgm_page | output | ADDR_W-7 | Page address for programming |

## Verification
Corrupted state shows up at the ports within a cycle or two of the event that uses it:

- A stale or wrong previous-location register either cuts a load short with an early `load_end` and `pgm_start`, or lets a real terminator through as a latch write in the very cycle of the strobe.
- A width latch that follows `arm_word` after arming moves `buf_be` from a single lane to both lanes on the next strobe.
- An idle counter that is not restarted on every strobe, or that uses the wrong limit, moves `load_end` off its expected cycle. Comparing every cycle against a model pins down the exact offset.
- A bad page capture is visible on `pgm_page` for the whole wait for `pgm_ack`.

// File: rtl/pl_pkg.sv
package pl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pl_state_e;

  // Byte-lane write enables for one load.
  function automatic logic [1:0] lane_enable(input logic word_mode, input logic lsb);
    if (word_mode) return 2'b11;
    return lsb ? 2'b10 : 2'b01;
  endfunction

  // Byte loads are replicated onto both halves of the latch word.
  function automatic logic [15:0] lane_data(input logic word_mode, input logic [15:0] d);
    return word_mode ? d : {d[7:0], d[7:0]};
  endfunction

  // A terminator is legal only when it carries zero.
  function automatic logic term_nonzero(input logic word_mode, input logic [15:0] d);
    return word_mode ? (|d) : (|d[7:0]);
  endfunction
endpackage

// File: rtl/pl_timer.sv
module pl_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = run && !restart && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || restart) cnt <= '0;
    else if (!expire)        cnt <= cnt + CNT_W'(1);
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));
endmodule

// File: rtl/pl_dup_detect.sv
module pl_dup_detect #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stb,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              dup,
  output logic [ADDR_W-8:0] page
);
  logic [ADDR_W-1:0] prev;
  logic              have_prev;
  logic              same;

  assign same = word_mode ? (prev[ADDR_W-1:1] == addr[ADDR_W-1:1]) : (prev == addr);
  assign dup  = have_prev && same;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev      <= '0;
      have_prev <= 1'b0;
      page      <= '0;
    end else if (clr) begin
      have_prev <= 1'b0;
      page      <= '0;
    end else if (stb) begin
      prev      <= addr;
      have_prev <= 1'b1;
      if (!have_prev) page <= addr[ADDR_W-1:7];
    end
  end

  // R7
  page_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && have_prev && !clr) |=> $stable(page));
endmodule

// File: rtl/pl_lane_map.sv
module pl_lane_map
  import pl_pkg::*;
(
  input  logic        wr,
  input  logic        word_mode,
  input  logic [6:0]  loc,
  input  logic [15:0] din,
  output logic [1:0]  be,
  output logic [5:0]  widx,
  output logic [15:0] wdata
);
  assign be    = wr ? lane_enable(word_mode, loc[0]) : 2'b00;
  assign widx  = loc[6:1];
  assign wdata = lane_data(word_mode, din);

  // R3
  always_comb begin
    if (wr && !word_mode) lane_single_chk: assert ($countones(be) == 1);
  end
endmodule

// File: rtl/flash_page_loader.sv
module flash_page_loader
  import pl_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int TMO_PGM = 5000,
  parameter int TMO_BUF = 1500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_valid,
  input  logic              arm_buf,
  input  logic              arm_word,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [15:0]       ld_data,
  input  logic              pgm_ack,
  output logic              loading,
  output logic              buf_clr,
  output logic [1:0]        buf_be,
  output logic [5:0]        buf_widx,
  output logic [15:0]       buf_wdata,
  output logic              load_end,
  output logic              end_dup,
  output logic              rsvd_flag,
  output logic              pgm_start,
  output logic [ADDR_W-8:0] pgm_page
);
  localparam int TMO_MAX = (TMO_PGM > TMO_BUF) ? TMO_PGM : TMO_BUF;
  localparam int CNT_W   = $clog2(TMO_MAX + 1);
  localparam logic [CNT_W-1:0] LIM_PGM = CNT_W'(TMO_PGM);
  localparam logic [CNT_W-1:0] LIM_BUF = CNT_W'(TMO_BUF);

  pl_state_e state, state_nx;
  logic kind_buf_q, word_q;

  // Named internal events
  logic arm_ok, accept, dup, term, wr, expire, finish_now;

  assign arm_ok     = (state == ST_IDLE) && arm_valid;
  assign accept     = (state == ST_LOAD) && ld_stb;
  assign term       = accept && !kind_buf_q && dup;
  assign wr         = accept && !term;
  assign finish_now = term || expire;
  assign loading    = (state == ST_LOAD);
  assign buf_clr    = arm_ok && !arm_buf;

  pl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(loading), .restart(accept),
    .limit(kind_buf_q ? LIM_BUF : LIM_PGM), .expire(expire)
  );

  pl_dup_detect #(.ADDR_W(ADDR_W)) u_dup (
    .clk(clk), .rst_n(rst_n), .clr(arm_ok), .stb(accept),
    .word_mode(word_q), .addr(ld_addr), .dup(dup), .page(pgm_page)
  );

  pl_lane_map u_lane (
    .wr(wr), .word_mode(word_q), .loc(ld_addr[6:0]), .din(ld_data),
    .be(buf_be), .widx(buf_widx), .wdata(buf_wdata)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (arm_ok) state_nx = ST_LOAD;
      ST_LOAD: begin
        if (term)        state_nx = ST_PROG;
        else if (expire) state_nx = kind_buf_q ? ST_IDLE : ST_PROG;
      end
      ST_PROG: if (pgm_ack) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind_buf_q <= 1'b0;
      word_q     <= 1'b0;
      load_end   <= 1'b0;
      pgm_start  <= 1'b0;
      rsvd_flag  <= 1'b0;
      end_dup    <= 1'b0;
    end else begin
      state     <= state_nx;
      load_end  <= finish_now;
      pgm_start <= term || (expire && !kind_buf_q);
      rsvd_flag <= term && term_nonzero(word_q, ld_data);
      if (arm_ok) begin
        kind_buf_q <= arm_buf;
        word_q     <= arm_word;
      end
      if (finish_now) end_dup <= term;
    end
  end

  // R5
  start_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> load_end);

  // R6
  rsvd_needs_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_flag |-> (load_end && end_dup));

  // R8
  buf_end_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_end && kind_buf_q) |-> !pgm_start);

  // R10
  prog_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |-> (buf_be == 2'b00));

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && !pgm_ack) |=> $stable(pgm_page));
endmodule

// File: tb/flash_page_loader_bench.sv
module flash_page_loader_bench;
  localparam int TP = 20;
  localparam int TB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic av = 0, ab = 0, aw = 0, st = 0, ak = 0;
  logic [19:0] ad = '0;
  logic [15:0] dt = '0;

  logic loading, buf_clr, load_end, end_dup, rsvd_flag, pgm_start;
  logic [1:0] buf_be;
  logic [5:0] buf_widx;
  logic [15:0] buf_wdata;
  logic [12:0] pgm_page;

  always #10 clk = ~clk;

  flash_page_loader #(.ADDR_W(20), .TMO_PGM(TP), .TMO_BUF(TB)) u_flash_page_loader (
    .clk(clk), .rst_n(rst_n), .arm_valid(av), .arm_buf(ab), .arm_word(aw),
    .ld_stb(st), .ld_addr(ad), .ld_data(dt), .pgm_ack(ak),
    .loading(loading), .buf_clr(buf_clr), .buf_be(buf_be), .buf_widx(buf_widx),
    .buf_wdata(buf_wdata), .load_end(load_end), .end_dup(end_dup),
    .rsvd_flag(rsvd_flag), .pgm_start(pgm_start), .pgm_page(pgm_page)
  );

  int vectors = 0, errs = 0;
  string phase = "R1";

  // Behavioural reference: 0 idle, 1 loading, 2 waiting for ack
  int m_st = 0, m_cnt = 0, m_prev = 0, m_page = 0;
  bit m_buf = 0, m_word = 0, m_hp = 0;
  bit m_end = 0, m_start = 0, m_rsvd = 0, m_cause = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s [%s]: got %0h expected %0h", req, phase, act, exp);
    end
  endtask

  task automatic cyc(input bit a_v, input bit a_b, input bit a_w, input bit s,
                     input logic [19:0] a, input logic [15:0] d, input bit k);
    bit acc, isdup, wr;
    int e_be;
    av = a_v; ab = a_b; aw = a_w; st = s; ad = a; dt = d; ak = k;
    #2;
    acc = (m_st == 1) && s;
    isdup = acc && !m_buf && m_hp &&
            (m_word ? ((m_prev >> 1) == (int'(a) >> 1)) : (m_prev == int'(a)));
    wr = acc && !isdup;
    e_be = !wr ? 0 : (m_word ? 3 : (a[0] ? 2 : 1));
    chk("R10 loading", 32'(loading), 32'(m_st == 1));
    chk("R2 buf_clr", 32'(buf_clr), 32'(m_st == 0 && a_v && !a_b));
    chk("R3 buf_be", 32'(buf_be), 32'(e_be));
    if (wr) begin
      chk("R3 buf_widx", 32'(buf_widx), (int'(a) >> 1) & 63);
      chk("R3 buf_wdata", 32'(buf_wdata), m_word ? 32'(d) : 32'({d[7:0], d[7:0]}));
    end
    chk("R4 load_end", 32'(load_end), 32'(m_end));
    chk("R5 pgm_start", 32'(pgm_start), 32'(m_start));
    chk("R6 rsvd_flag", 32'(rsvd_flag), 32'(m_rsvd));
    if (m_end) chk("R5 end_dup", 32'(end_dup), 32'(m_cause));
    if (m_st == 2) chk("R7 pgm_page", 32'(pgm_page), m_page);
    @(posedge clk);
    m_end = 0; m_start = 0; m_rsvd = 0;
    case (m_st)
      0: if (a_v) begin
        m_st = 1; m_buf = a_b; m_word = a_w; m_cnt = 0; m_hp = 0; m_page = 0;
      end
      1: if (acc) begin
        if (isdup) begin
          m_end = 1; m_start = 1; m_cause = 1; m_st = 2;
          m_rsvd = m_word ? (d != 0) : (d[7:0] != 0);
        end else begin
          if (!m_hp) m_page = int'(a) >> 7;
          m_hp = 1; m_prev = int'(a); m_cnt = 0;
        end
      end else begin
        m_cnt++;
        if (m_cnt == (m_buf ? TB : TP)) begin
          m_end = 1; m_cause = 0;
          if (m_buf) m_st = 0;
          else begin m_st = 2; m_start = 1; end
        end
      end
      default: if (k) m_st = 0;
    endcase
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0, '0, 0);
  endtask
  task automatic arm(input bit b, input bit w);
    cyc(1, b, w, 0, '0, '0, 0);
  endtask
  task automatic ld(input logic [19:0] a, input logic [15:0] d);
    cyc(0, 0, 0, 1, a, d, 0);
  endtask
  task automatic ack();
    cyc(0, 0, 0, 0, '0, '0, 1);
  endtask

  initial begin
    #(TP * 1000 * 20);
    errs++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    phase = "R1"; idle(2);
    phase = "R11"; ld(20'h05285, 16'h00AA); ld(20'h05285, 16'h0000);
    // Program, byte mode, out-of-order loads, ends on timeout
    phase = "R2 R3 R4"; arm(0, 0);
    ld(20'h05285, 16'h0011); idle(3); ld(20'h052FF, 16'h0022);
    ld(20'h05280, 16'h1233); ld(20'h05285, 16'h0044); idle(TP + 2);
    phase = "R10"; ld(20'h05281, 16'h0055); arm(1, 1); idle(2); ack(); idle(2);
    // Program, byte mode, repeated location with zero terminator
    phase = "R5"; arm(0, 0); ld(20'h00903, 16'h00AB); ld(20'h00909, 16'h00CD);
    ld(20'h00909, 16'hFF00); idle(3); ack();
    // Program, word mode, non-zero terminator, low address bit ignored
    phase = "R6"; arm(0, 1); ld(20'h7FF10, 16'hBEEF); ld(20'h7FF11, 16'h0100);
    idle(2); ack(); idle(1);
    // Program with no loads: page 0
    phase = "R7"; arm(0, 1); idle(TP + 3); ack();
    // Write-buffer mode: repeats are plain writes, short timeout, no start
    phase = "R8"; arm(1, 0); ld(20'h00044, 16'h0066); ld(20'h00044, 16'h0000);
    ld(20'h00045, 16'h0077); idle(TB + 3);
    phase = "R11"; ld(20'h00046, 16'h0088);
    // Width latched at arm
    phase = "R9"; arm(0, 0);
    cyc(0, 0, 1, 1, 20'h01201, 16'h3399, 0);
    cyc(0, 0, 1, 1, 20'h01200, 16'h4455, 0);
    cyc(0, 0, 1, 1, 20'h01201, 16'h0000, 0);
    idle(2); ack(); idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule